// File: doc/BRIEF.md
# UART Modem-Line Loopback Path

This block sits between a UART's control-register decode and its receive queue. Software enables an internal loop by setting one bit in the control word. While the loop is active, the four modem-control outputs written by software (RTS, DTR and two general-purpose outputs) are reflected straight back onto the modem-status flags through a fixed cross-mapping. Every control write that keeps the loop active also produces a fresh modem-interrupt vector, rebuilt entirely from the new flags. Words written for transmission, together with a marker word each time a send-break is raised, are steered into the receive queue. Characters arriving on the external receive input are dropped.

While the loop is off, the status flags come straight from the external modem pins. External received characters pass through to the receive queue, and transmit writes are accepted without producing anything on the queue side. The block works at the register level only; serial bit timing is handled elsewhere.

The receive-queue port and the two character inputs are valid/ready streams. A transfer takes place on a rising clock edge where valid and ready are both high. A producer that has raised valid holds it and its data until the transfer. The queue may lower `rxq_ready` at any time. That back-pressure reaches the transmit-write input while the loop is active, or the external input while it is not. The input not selected by the loop always sees ready high and is consumed immediately.

Top module: `uart_loopback_path`

## Requirements
- R1: After reset the loop is off. `mdm_flags` equals `mdm_pins`, `ms_irq_wr` is low and `rxq_valid` is low unless `ext_rx_valid` is high.
- R2: The control word has loop enable at bit 7, DTR at bit 10, RTS at bit 11, OUT1 at bit 12 and OUT2 at bit 13. With the loop active, `mdm_flags` reads [3]=OUT2, [2]=OUT1, [1]=DTR and [0]=RTS, all taken from the last control write.
- R3: The mapping takes effect in the cycle after the same control write that sets the loop-enable bit. No later write is needed.
- R4: A control write with bit 7 set pulses `ms_irq_wr` high for exactly the next cycle. `ms_irq_bits` then equals the new flags, so a line that dropped reports 0. A control write with bit 7 clear gives no pulse.
- R5: With the loop active, each transmit write transfers in the same cycle onto the receive queue as the byte zero-extended to 12 bits. `data_wr_ready` follows `rxq_ready`.
- R6: With the loop already active, a 0-to-1 change of `lcr_break` queues one word with only bit 10 set (0x400). A falling edge, a held level, or a rise while the loop is off queues nothing.
- R7: With the loop active, `ext_rx_ready` is high and external characters are consumed without reaching the receive queue.
- R8: With the loop off, `mdm_flags` tracks `mdm_pins`, external characters pass zero-extended to the receive queue under its back-pressure, and transmit writes are accepted with `data_wr_ready` high and no queue traffic.
- R9: A queued break word is offered before any transmit write. `data_wr_ready` stays low until that word has transferred.
- R10: Control-word bits other than 7, 10, 11, 12 and 13 have no effect on the flags or on the interrupt vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr_en | input | 1 | Control-register write strobe |
| ctl_wr_data | input | 16 | Control-register write value |
| lcr_break | input | 1 | Current send-break bit of the line-control register |
| mdm_pins | input | 4 | External modem status {RI, DCD, DSR, CTS} |
| data_wr_valid | input | 1 | Transmit write valid |
| data_wr_data | input | 8 | Transmit write byte |
| data_wr_ready | output | 1 | Transmit write ready |
| ext_rx_valid | input | 1 | External received character valid |
| ext_rx_data | input | 8 | External received character |
| ext_rx_ready | output | 1 | External received character ready |
| mdm_flags | output | 4 | Modem-status flags {RI, DCD, DSR, CTS} |
| ms_irq_wr | output | 1 | One-cycle strobe: rewrite the modem interrupt bits |
| ms_irq_bits | output | 4 | New modem interrupt bits {RI, DCD, DSR, CTS} |
| rxq_valid | output | 1 | Receive-queue push valid |
| rxq_data | output | 12 | Receive-queue push word |
| rxq_ready | input | 1 | Receive-queue ready |

## Verification
The line mapping is tried with single lines, with a mix that drops a line set by the previous write, with all four lines set, and with every unrelated control bit set while all four lines are clear. These patterns separate a swapped pair of lines from a missing clear of the interrupt vector, and from a decode of the wrong bit. Transmit writes and break edges are compared in order against a queue of expected words. A stalled queue with a break and a data write both waiting shows whether the break takes priority. Falling or held break levels, and external characters offered while the loop is active, must leave the queue untouched. With the loop off, the same stimuli must give pin-driven flags and pass-through of external characters.

// File: rtl/uart_lb_pkg.sv
package uart_lb_pkg;
  localparam int CTL_W     = 16;
  localparam int LBE_BIT   = 7;
  localparam int DTR_BIT   = 10;
  localparam int RTS_BIT   = 11;
  localparam int OUT1_BIT  = 12;
  localparam int OUT2_BIT  = 13;
  localparam int LINES     = 4;

  // Flag vector order: [3] RI, [2] DCD, [1] DSR, [0] CTS
  typedef struct packed {
    logic ri;
    logic dcd;
    logic dsr;
    logic cts;
  } mdm_lines_t;

  function automatic mdm_lines_t cross_map(input logic [CTL_W-1:0] w);
    mdm_lines_t m;
    m.ri  = w[OUT2_BIT];
    m.dcd = w[OUT1_BIT];
    m.dsr = w[DTR_BIT];
    m.cts = w[RTS_BIT];
    return m;
  endfunction
endpackage

// File: rtl/ulb_ctl_capture.sv
module ulb_ctl_capture
  import uart_lb_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ctl_wr_en,
  input  logic [CTL_W-1:0]     ctl_wr_data,
  output logic                 lbe_act,
  output logic [LINES-1:0]     loop_flags,
  output logic                 irq_wr,
  output logic [LINES-1:0]     irq_bits
);
  mdm_lines_t next_lines;
  logic       new_lbe;
  logic       ctl_unused;

  assign next_lines = cross_map(ctl_wr_data);
  assign new_lbe    = ctl_wr_data[LBE_BIT];
  assign ctl_unused = ^{ctl_wr_data[CTL_W-1:OUT2_BIT+1], ctl_wr_data[DTR_BIT-1:LBE_BIT+1],
                        ctl_wr_data[LBE_BIT-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lbe_act    <= 1'b0;
      loop_flags <= '0;
      irq_wr     <= 1'b0;
      irq_bits   <= '0;
    end else begin
      irq_wr <= ctl_wr_en && new_lbe;
      if (ctl_wr_en) begin
        lbe_act <= new_lbe;
        if (new_lbe) begin
          loop_flags <= next_lines;
          irq_bits   <= next_lines;
        end
      end
    end
  end
endmodule

// File: rtl/ulb_break_track.sv
module ulb_break_track (
  input  logic clk,
  input  logic rst_n,
  input  logic lbe_act,
  input  logic lcr_break,
  input  logic taken,
  output logic brk_pend
);
  logic brk_prev;
  logic brk_rise;

  assign brk_rise = lcr_break && !brk_prev && lbe_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      brk_prev <= 1'b0;
      brk_pend <= 1'b0;
    end else begin
      brk_prev <= lcr_break;
      if (!lbe_act)      brk_pend <= 1'b0;
      else if (brk_rise) brk_pend <= 1'b1;
      else if (taken)    brk_pend <= 1'b0;
    end
  end
endmodule

// File: rtl/ulb_push_arb.sv
module ulb_push_arb #(
  parameter int DATA_W  = 8,
  parameter int PUSH_W  = 12,
  parameter int BRK_BIT = 10
) (
  input  logic              lbe_act,
  input  logic              brk_pend,
  input  logic              data_wr_valid,
  input  logic [DATA_W-1:0] data_wr_data,
  output logic              data_wr_ready,
  input  logic              ext_rx_valid,
  input  logic [DATA_W-1:0] ext_rx_data,
  output logic              ext_rx_ready,
  output logic              rxq_valid,
  output logic [PUSH_W-1:0] rxq_data,
  input  logic              rxq_ready,
  output logic              brk_taken
);
  localparam logic [PUSH_W-1:0] BRK_WORD = {{(PUSH_W-1){1'b0}}, 1'b1} << BRK_BIT;
  localparam int PAD_W = PUSH_W - DATA_W;

  always_comb begin
    brk_taken = 1'b0;
    if (lbe_act) begin
      ext_rx_ready = 1'b1;
      if (brk_pend) begin
        rxq_valid     = 1'b1;
        rxq_data      = BRK_WORD;
        data_wr_ready = 1'b0;
        brk_taken     = rxq_ready;
      end else begin
        rxq_valid     = data_wr_valid;
        rxq_data      = {{PAD_W{1'b0}}, data_wr_data};
        data_wr_ready = rxq_ready;
      end
    end else begin
      data_wr_ready = 1'b1;
      rxq_valid     = ext_rx_valid;
      rxq_data      = {{PAD_W{1'b0}}, ext_rx_data};
      ext_rx_ready  = rxq_ready;
    end
  end
endmodule

// File: rtl/uart_loopback_path.sv
module uart_loopback_path
  import uart_lb_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int PUSH_W  = 12,
  parameter int BRK_BIT = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr_en,
  input  logic [15:0]       ctl_wr_data,
  input  logic              lcr_break,
  input  logic [3:0]        mdm_pins,
  input  logic              data_wr_valid,
  input  logic [DATA_W-1:0] data_wr_data,
  output logic              data_wr_ready,
  input  logic              ext_rx_valid,
  input  logic [DATA_W-1:0] ext_rx_data,
  output logic              ext_rx_ready,
  output logic [3:0]        mdm_flags,
  output logic              ms_irq_wr,
  output logic [3:0]        ms_irq_bits,
  output logic              rxq_valid,
  output logic [PUSH_W-1:0] rxq_data,
  input  logic              rxq_ready
);
  logic             lbe_act;
  logic [LINES-1:0] loop_flags;
  logic             brk_pend;
  logic             brk_taken;

  ulb_ctl_capture u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_wr_en  (ctl_wr_en),
    .ctl_wr_data(ctl_wr_data),
    .lbe_act    (lbe_act),
    .loop_flags (loop_flags),
    .irq_wr     (ms_irq_wr),
    .irq_bits   (ms_irq_bits)
  );

  ulb_break_track u_brk (
    .clk      (clk),
    .rst_n    (rst_n),
    .lbe_act  (lbe_act),
    .lcr_break(lcr_break),
    .taken    (brk_taken),
    .brk_pend (brk_pend)
  );

  ulb_push_arb #(.DATA_W(DATA_W), .PUSH_W(PUSH_W), .BRK_BIT(BRK_BIT)) u_arb (
    .lbe_act      (lbe_act),
    .brk_pend     (brk_pend),
    .data_wr_valid(data_wr_valid),
    .data_wr_data (data_wr_data),
    .data_wr_ready(data_wr_ready),
    .ext_rx_valid (ext_rx_valid),
    .ext_rx_data  (ext_rx_data),
    .ext_rx_ready (ext_rx_ready),
    .rxq_valid    (rxq_valid),
    .rxq_data     (rxq_data),
    .rxq_ready    (rxq_ready),
    .brk_taken    (brk_taken)
  );

  assign mdm_flags = lbe_act ? loop_flags : mdm_pins;
endmodule

// File: rtl/ulb_checker.sv
module ulb_checker #(
  parameter int DATA_W = 8,
  parameter int PUSH_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ctl_wr_en,
  input logic [15:0]       ctl_wr_data,
  input logic              data_wr_valid,
  input logic [DATA_W-1:0] data_wr_data,
  input logic              data_wr_ready,
  input logic              ext_rx_valid,
  input logic              ext_rx_ready,
  input logic [3:0]        mdm_flags,
  input logic              ms_irq_wr,
  input logic [3:0]        ms_irq_bits,
  input logic              rxq_valid,
  input logic [PUSH_W-1:0] rxq_data,
  input logic              rxq_ready,
  input logic              lbe_act,
  input logic              brk_pend
);
  a_r2_cross_map: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr_en && ctl_wr_data[7] |=> mdm_flags ==
      {$past(ctl_wr_data[13]), $past(ctl_wr_data[12]), $past(ctl_wr_data[10]), $past(ctl_wr_data[11])});

  a_r4_vector: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr_en && ctl_wr_data[7] |=> ms_irq_wr && ms_irq_bits == mdm_flags);

  a_r4_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctl_wr_en && ctl_wr_data[7]) |=> !ms_irq_wr);

  a_r5_tx_push: assert property (@(posedge clk) disable iff (!rst_n)
    lbe_act && data_wr_valid && data_wr_ready |->
      rxq_valid && rxq_ready && rxq_data == {{(PUSH_W-DATA_W){1'b0}}, data_wr_data});

  a_r7_discard: assert property (@(posedge clk) disable iff (!rst_n)
    lbe_act |-> ext_rx_ready);

  a_r8_pass: assert property (@(posedge clk) disable iff (!rst_n)
    !lbe_act |-> rxq_valid == ext_rx_valid && data_wr_ready);

  a_r9_break_first: assert property (@(posedge clk) disable iff (!rst_n)
    lbe_act && brk_pend |-> !data_wr_ready && rxq_valid);
endmodule

bind uart_loopback_path ulb_checker #(.DATA_W(DATA_W), .PUSH_W(PUSH_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ctl_wr_en    (ctl_wr_en),
  .ctl_wr_data  (ctl_wr_data),
  .data_wr_valid(data_wr_valid),
  .data_wr_data (data_wr_data),
  .data_wr_ready(data_wr_ready),
  .ext_rx_valid (ext_rx_valid),
  .ext_rx_ready (ext_rx_ready),
  .mdm_flags    (mdm_flags),
  .ms_irq_wr    (ms_irq_wr),
  .ms_irq_bits  (ms_irq_bits),
  .rxq_valid    (rxq_valid),
  .rxq_data     (rxq_data),
  .rxq_ready    (rxq_ready),
  .lbe_act      (lbe_act),
  .brk_pend     (brk_pend)
);

// File: tb/tb_uart_loopback_path.sv
module tb_uart_loopback_path;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_wr_en = 1'b0;
  logic [15:0] ctl_wr_data = '0;
  logic        lcr_break = 1'b0;
  logic [3:0]  mdm_pins = 4'b0101;
  logic        data_wr_valid = 1'b0;
  logic [7:0]  data_wr_data = '0;
  logic        data_wr_ready;
  logic        ext_rx_valid = 1'b0;
  logic [7:0]  ext_rx_data = '0;
  logic        ext_rx_ready;
  logic [3:0]  mdm_flags;
  logic        ms_irq_wr;
  logic [3:0]  ms_irq_bits;
  logic        rxq_valid;
  logic [11:0] rxq_data;
  logic        rxq_ready = 1'b1;

  int checks = 0;
  int errors = 0;
  logic [11:0] expq[$];

  always #10 clk = ~clk;

  uart_loopback_path dut (
    .clk(clk), .rst_n(rst_n), .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
    .lcr_break(lcr_break), .mdm_pins(mdm_pins), .data_wr_valid(data_wr_valid),
    .data_wr_data(data_wr_data), .data_wr_ready(data_wr_ready),
    .ext_rx_valid(ext_rx_valid), .ext_rx_data(ext_rx_data), .ext_rx_ready(ext_rx_ready),
    .mdm_flags(mdm_flags), .ms_irq_wr(ms_irq_wr), .ms_irq_bits(ms_irq_bits),
    .rxq_valid(rxq_valid), .rxq_data(rxq_data), .rxq_ready(rxq_ready)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: a transfer seen here completes on the coming rising edge
  always @(negedge clk) begin
    if (rst_n && rxq_valid && rxq_ready) begin
      if (expq.size() == 0) begin
        checks++; errors++;
        $display("FAIL R5/R6/R7 unexpected push actual=%h expected=none", rxq_data);
      end else begin
        check("R5/R6/R8/R9 queue order", {4'h0, rxq_data}, {4'h0, expq.pop_front()});
      end
    end
  end

  task automatic ctl_write(input logic [15:0] v);
    @(negedge clk);
    ctl_wr_en = 1'b1; ctl_wr_data = v;
    @(negedge clk);
    ctl_wr_en = 1'b0;
  endtask

  task automatic tx_write(input logic [7:0] b, input logic looped);
    @(negedge clk);
    data_wr_valid = 1'b1; data_wr_data = b;
    if (looped) expq.push_back({4'h0, b});
    while (!data_wr_ready) @(negedge clk);
    @(negedge clk);
    data_wr_valid = 1'b0;
  endtask

  task automatic ext_char(input logic [7:0] b, input logic passes);
    @(negedge clk);
    ext_rx_valid = 1'b1; ext_rx_data = b;
    if (passes) expq.push_back({4'h0, b});
    while (!ext_rx_ready) @(negedge clk);
    @(negedge clk);
    ext_rx_valid = 1'b0;
  endtask

  task automatic set_break(input logic v, input logic pushes);
    @(negedge clk);
    lcr_break = v;
    if (pushes) expq.push_back(12'h400);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 flags from pins", {12'h0, mdm_flags}, 16'h0005);
    check("R1 no strobe", {15'h0, ms_irq_wr}, 16'h0);
    check("R1 no push", {15'h0, rxq_valid}, 16'h0);

    // R8 loop off
    ext_char(8'h41, 1'b1);
    tx_write(8'h55, 1'b0);
    mdm_pins = 4'b1010;
    @(negedge clk);
    check("R8 flags track pins", {12'h0, mdm_flags}, 16'h000A);
    check("R8 tx ready", {15'h0, data_wr_ready}, 16'h1);

    // R3 + R2: enable with RTS only
    ctl_write(16'h0880);
    check("R3 map on enabling write", {12'h0, mdm_flags}, 16'h0001);
    check("R4 strobe", {15'h0, ms_irq_wr}, 16'h1);
    check("R4 bits", {12'h0, ms_irq_bits}, 16'h0001);
    @(negedge clk);
    check("R4 single pulse", {15'h0, ms_irq_wr}, 16'h0);
    // R2 mixed lines; CTS must drop
    ctl_write(16'h3480);
    check("R2 mixed map", {12'h0, mdm_flags}, 16'h000E);
    check("R4 rebuilt bits", {12'h0, ms_irq_bits}, 16'h000E);
    ctl_write(16'h3C80);
    check("R2 all lines", {12'h0, mdm_flags}, 16'h000F);
    // R10 unrelated bits set, lines clear
    ctl_write(16'hC37F | 16'h0080);
    check("R10 unrelated bits", {12'h0, mdm_flags}, 16'h0000);
    check("R10 strobe bits clear", {12'h0, ms_irq_bits}, 16'h0000);

    // R5 transmit loop
    tx_write(8'hA5, 1'b1);
    tx_write(8'h3C, 1'b1);
    // R7 external discarded
    @(negedge clk);
    ext_rx_valid = 1'b1; ext_rx_data = 8'h77;
    @(negedge clk);
    check("R7 ext ready", {15'h0, ext_rx_ready}, 16'h1);
    check("R7 no push", {15'h0, rxq_valid}, 16'h0);
    ext_rx_valid = 1'b0;

    // R6 break edges
    set_break(1'b1, 1'b1);
    set_break(1'b1, 1'b0);
    set_break(1'b0, 1'b0);
    set_break(1'b1, 1'b1);
    set_break(1'b0, 1'b0);

    // R9 break before data under back-pressure
    @(negedge clk);
    rxq_ready = 1'b0;
    set_break(1'b1, 1'b1);
    fork
      tx_write(8'h99, 1'b1);
      begin
        repeat (3) @(negedge clk);
        check("R9 data held", {15'h0, data_wr_ready}, 16'h0);
        check("R9 break offered", {4'h0, rxq_data}, 16'h0400);
        rxq_ready = 1'b1;
      end
    join
    set_break(1'b0, 1'b0);

    // Loop off: no strobe, pin flags, break ignored
    ctl_write(16'h0300);
    check("R4 no strobe when loop off", {15'h0, ms_irq_wr}, 16'h0);
    check("R8 flags back to pins", {12'h0, mdm_flags}, 16'h000A);
    set_break(1'b1, 1'b0);
    repeat (3) @(negedge clk);
    check("R6 queue drained", 16'(expq.size()), 16'h0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule